// File: doc/BRIEF.md
# Dual Quadrature Position Counter with Decimal Readout

This block tracks two independent positions, each fed by an incremental encoder that produces two square waves a quarter period apart. For each channel the two phase lines are brought into the clock domain and decoded at four counts per cycle. A 24-bit up/down counter then holds the position. The two counters start running as soon as reset is released. No further enable is needed.

A host drives a small set of control inputs. A single stop input freezes both counters. Each counter has its own clear command, which acts on the rising edge only. A mode nibble permits counting only in the plain-counter mode (code 0). A format nibble chooses how the present values are reported: either the raw binary count, or the low six decimal digits packed as BCD. The BCD form comes from one serial shift-and-add-3 converter per channel. Each converter rescans its counter continuously and signals each fresh result.

Top module: `dual_quad_counter`

## Requirements
- R1: Counting is permitted only while `op_mode` is 0. Any other code freezes both counters, but clear edges still act.
- R2: Decoding works on a position index computed from the two phase lines, {B, A xor B}. This gives AB=00 → 0, AB=10 → 1, AB=11 → 2 and AB=01 → 3. A step of +1 (mod 4) raises the count by one and a step of −1 lowers it by one. A phase state present at clock edge k is counted at edge k+2, and in binary format it shows on the output after edge k+3.
- R3: A change of both phase lines between two synchronized samples is a step of 2 and leaves the count unchanged.
- R4: While `halt` is 1, neither counter changes. Phase movement seen during that time is discarded and is not counted afterwards.
- R5: A rising edge of `clr1` or `clr2` clears only its own counter, at that edge. Holding the command high does not clear again, and counting continues.
- R6: When a clear edge and a count event fall on the same edge, the clear wins and the counter ends at 0.
- R7: The counters are 24 bits wide and wrap modulo 2^24 in both directions.
- R8: When `fmt_sel` is nonzero, each output carries the binary count held before the previous edge, and its update flag is 1 every cycle.
- R9: When `fmt_sel` is 0, each output carries the count modulo 10^6 as six packed BCD digits, least significant digit in bits 3:0. Every nibble is 9 or less. The update flag pulses for one cycle each time a new value is loaded, once every 25 cycles.
- R10: A synchronous reset sets both counts and both outputs to 0 and both update flags to 0.
- R11: Once reset is released, counting proceeds with no other enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_mode | input | 4 | Operating mode, 0 = plain counting |
| fmt_sel | input | 4 | Output format, 0 = BCD, nonzero = binary |
| halt | input | 1 | Freezes both counters while high |
| clr1 | input | 1 | Clear command for counter 1, rising edge |
| clr2 | input | 1 | Clear command for counter 2, rising edge |
| qa1 | input | 1 | Channel 1 phase A |
| qb1 | input | 1 | Channel 1 phase B |
| qa2 | input | 1 | Channel 2 phase A |
| qb2 | input | 1 | Channel 2 phase B |
| pv1 | output | 24 | Present value of counter 1 |
| pv2 | output | 24 | Present value of counter 2 |
| upd1 | output | 1 | Counter 1 output freshly loaded |
| upd2 | output | 1 | Counter 2 output freshly loaded |

## Verification
The properties assume that `halt`, the clear commands and the two mode nibbles are already synchronous to `clk`, so that an edge of a clear command is seen where the checker samples it. The phase lines are treated as asynchronous. The stimulus changes every input half a cycle away from the active edge. It holds each phase state for two cycles and moves one phase line at a time, except in the one deliberate double jump. Decimal results are compared only after the count has been still long enough for a whole conversion to have started from the current value.

// File: rtl/dqc_pkg.sv
package dqc_pkg;

  localparam logic [3:0] MODE_SIMPLE = 4'd0;
  localparam logic [3:0] FMT_BCD     = 4'd0;

  typedef enum logic {CONV_IDLE, CONV_RUN} conv_state_e;

  // position index along the four-state phase cycle: {B, A^B}
  function automatic logic [1:0] quad_pos(input logic [1:0] ab);
    return {ab[0], ab[1] ^ ab[0]};
  endfunction

endpackage

// File: rtl/quad_decode.sv
module quad_decode #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic phase_a,
  input  logic phase_b,
  output logic step_up,
  output logic step_dn
);
  import dqc_pkg::*;

  logic [1:0] sync_q [SYNC_STAGES];
  logic [1:0] prev_q;
  logic [1:0] delta;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= {phase_a, phase_b};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  always_comb delta = quad_pos(sync_q[SYNC_STAGES-1]) - quad_pos(prev_q);

  // a step of two positions cannot tell direction and is dropped
  assign step_up = (delta == 2'd1);
  assign step_dn = (delta == 2'd3);

endmodule

// File: rtl/updown_cnt.sv
module updown_cnt #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         up,
  input  logic         dn,
  input  logic         clr_cmd,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] ONE = W'(1);

  logic clr_prev;
  logic clr_edge;

  assign clr_edge = clr_cmd & ~clr_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      clr_prev <= 1'b0;
    end else begin
      clr_prev <= clr_cmd;
      if (clr_edge)        count <= '0;
      else if (en && up)   count <= count + ONE;
      else if (en && dn)   count <= count - ONE;
    end
  end

endmodule

// File: rtl/bin2bcd_iter.sv
module bin2bcd_iter #(
  parameter int BIN_W      = 24,
  parameter int DIGITS     = 8,
  parameter int OUT_DIGITS = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [BIN_W-1:0]        bin,
  output logic                    busy,
  output logic                    done,
  output logic [4*OUT_DIGITS-1:0] bcd
);
  import dqc_pkg::*;

  localparam int             CW   = $clog2(BIN_W);
  localparam logic [CW-1:0]  LAST = CW'(BIN_W - 1);
  localparam logic [CW-1:0]  INC  = CW'(1);

  conv_state_e           st_q;
  logic [CW-1:0]         n_q;
  logic [BIN_W-1:0]      sh_q, sh_nx;
  logic [4*DIGITS-1:0]   acc_q, acc_adj, acc_nx;

  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    assign acc_adj[4*d +: 4] = (acc_q[4*d +: 4] >= 4'd5) ? acc_q[4*d +: 4] + 4'd3
                                                         : acc_q[4*d +: 4];
  end

  assign {acc_nx, sh_nx} = {acc_adj, sh_q} << 1;
  assign busy = (st_q == CONV_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= CONV_IDLE;
      n_q   <= '0;
      sh_q  <= '0;
      acc_q <= '0;
      done  <= 1'b0;
      bcd   <= '0;
    end else begin
      done <= 1'b0;
      case (st_q)
        CONV_IDLE: begin
          if (start) begin
            sh_q  <= bin;
            acc_q <= '0;
            n_q   <= '0;
            st_q  <= CONV_RUN;
          end
        end
        default: begin
          sh_q  <= sh_nx;
          acc_q <= acc_nx;
          n_q   <= n_q + INC;
          if (n_q == LAST) begin
            st_q <= CONV_IDLE;
            done <= 1'b1;
            bcd  <= acc_nx[4*OUT_DIGITS-1:0];
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/dual_quad_counter.sv
module dual_quad_counter #(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op_mode,
  input  logic [3:0]       fmt_sel,
  input  logic             halt,
  input  logic             clr1,
  input  logic             clr2,
  input  logic             qa1,
  input  logic             qb1,
  input  logic             qa2,
  input  logic             qb2,
  output logic [CNT_W-1:0] pv1,
  output logic [CNT_W-1:0] pv2,
  output logic             upd1,
  output logic             upd2
);
  import dqc_pkg::*;

  localparam int NUM_CH      = 2;
  localparam int OUT_DIGITS  = CNT_W / 4;
  localparam int CONV_DIGITS = (CNT_W * 3) / 10 + 1;

  logic [NUM_CH-1:0] qa_v, qb_v, clr_v;
  logic              count_en;
  logic              bcd_sel;

  assign qa_v     = {qa2, qa1};
  assign qb_v     = {qb2, qb1};
  assign clr_v    = {clr2, clr1};
  assign count_en = ~halt & (op_mode == MODE_SIMPLE);
  assign bcd_sel  = (fmt_sel == FMT_BCD);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic                    up, dn, busy, done;
    logic [CNT_W-1:0]        cnt_q;
    logic [4*OUT_DIGITS-1:0] bcd_val;
    logic [CNT_W-1:0]        pv_q;
    logic                    upd_q;

    quad_decode #(.SYNC_STAGES(SYNC_STAGES)) u_dec (
      .clk(clk), .rst(rst), .phase_a(qa_v[ch]), .phase_b(qb_v[ch]),
      .step_up(up), .step_dn(dn)
    );

    updown_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .en(count_en), .up(up), .dn(dn),
      .clr_cmd(clr_v[ch]), .count(cnt_q)
    );

    bin2bcd_iter #(.BIN_W(CNT_W), .DIGITS(CONV_DIGITS), .OUT_DIGITS(OUT_DIGITS)) u_conv (
      .clk(clk), .rst(rst), .start(~busy), .bin(cnt_q),
      .busy(busy), .done(done), .bcd(bcd_val)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        pv_q  <= '0;
        upd_q <= 1'b0;
      end else if (!bcd_sel) begin
        pv_q  <= cnt_q;
        upd_q <= 1'b1;
      end else if (done) begin
        pv_q  <= bcd_val;
        upd_q <= 1'b1;
      end else begin
        upd_q <= 1'b0;
      end
    end
  end

  assign pv1  = g_ch[0].pv_q;
  assign pv2  = g_ch[1].pv_q;
  assign upd1 = g_ch[0].upd_q;
  assign upd2 = g_ch[1].upd_q;

endmodule

// File: rtl/dqc_checker.sv
module dqc_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       op_mode,
  input logic [3:0]       fmt_sel,
  input logic             halt,
  input logic             clr1,
  input logic             clr2,
  input logic [CNT_W-1:0] cnt1,
  input logic [CNT_W-1:0] cnt2,
  input logic [CNT_W-1:0] pv1,
  input logic [CNT_W-1:0] pv2,
  input logic             upd1,
  input logic             upd2
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic bit digits_ok(input logic [CNT_W-1:0] v);
    for (int i = 0; i < CNT_W / 4; i++)
      if (v[4*i +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  AST_MODE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (op_mode != 4'd0 && !(clr1 && !$past(clr1))) |=> cnt1 == $past(cnt1)); // R1

  AST_STEP_UNIT: assert property (@(posedge clk) disable iff (rst)
    !(clr2 && !$past(clr2)) |=>
      (cnt2 == $past(cnt2) || cnt2 == $past(cnt2) + ONE || cnt2 == $past(cnt2) - ONE)); // R2

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (halt && !(clr2 && !$past(clr2))) |=> cnt2 == $past(cnt2)); // R4

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (clr1 && !$past(clr1)) |=> cnt1 == '0); // R5

  AST_BIN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (fmt_sel != 4'd0) |=> (pv1 == $past(cnt1) && upd1 && pv2 == $past(cnt2) && upd2)); // R8

  AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (rst)
    (fmt_sel == 4'd0) |=> (!upd1 || digits_ok(pv1))); // R9

endmodule

bind dual_quad_counter dqc_checker #(.CNT_W(CNT_W)) u_dqc_checker (
  .clk(clk), .rst(rst), .op_mode(op_mode), .fmt_sel(fmt_sel), .halt(halt),
  .clr1(clr1), .clr2(clr2), .cnt1(g_ch[0].cnt_q), .cnt2(g_ch[1].cnt_q),
  .pv1(pv1), .pv2(pv2), .upd1(upd1), .upd2(upd2)
);

// File: tb/dual_quad_counter_bench.sv
module dual_quad_counter_bench;
  localparam int W = 24;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst = 1'b1;
  logic [3:0]   op_mode = 4'd0;
  logic [3:0]   fmt_sel = 4'd1;
  logic         halt = 1'b0;
  logic [1:0]   clr_v = 2'b00;
  logic [1:0]   ab [2];
  logic [W-1:0] pv1, pv2;
  logic         upd1, upd2;

  dual_quad_counter u_dual_quad_counter (
    .clk(clk), .rst(rst), .op_mode(op_mode), .fmt_sel(fmt_sel), .halt(halt),
    .clr1(clr_v[0]), .clr2(clr_v[1]),
    .qa1(ab[0][1]), .qb1(ab[0][0]), .qa2(ab[1][1]), .qb2(ab[1][0]),
    .pv1(pv1), .pv2(pv2), .upd1(upd1), .upd2(upd2)
  );

  int    checks = 0;
  int    fails = 0;
  int    bcd_seen = 0;
  string tag = "R10";

  // behavioural reference state
  logic [W-1:0] mc [2];
  logic [W-1:0] exp_pv [2];
  logic [1:0]   hist [2][4];
  logic         clr_last [2];
  int           stable [2];
  logic         e_rst;
  logic [3:0]   e_fmt;

  function automatic logic [1:0] pos_of(input logic [1:0] v);
    return {v[0], v[1] ^ v[0]};
  endfunction

  function automatic logic [1:0] ab_of(input logic [1:0] p);
    return {p[0] ^ p[1], p[1]};
  endfunction

  function automatic logic [W-1:0] to_bcd(input logic [W-1:0] v);
    int unsigned x = int'(v) % 1000000;
    logic [W-1:0] r = '0;
    for (int i = 0; i < 6; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    e_rst = rst;
    e_fmt = fmt_sel;
    for (int ch = 0; ch < 2; ch++) begin
      if (rst) begin
        mc[ch] = '0; exp_pv[ch] = '0; clr_last[ch] = 1'b0; stable[ch] = 0;
        for (int i = 0; i < 4; i++) hist[ch][i] = 2'b00;
      end else begin
        logic [W-1:0] old = mc[ch];
        logic         rise = clr_v[ch] && !clr_last[ch];
        logic [1:0]   d;
        for (int i = 3; i > 0; i--) hist[ch][i] = hist[ch][i-1];
        hist[ch][0] = ab[ch];
        clr_last[ch] = clr_v[ch];
        d = pos_of(hist[ch][2]) - pos_of(hist[ch][3]);
        if (rise) mc[ch] = '0;
        else if (!halt && op_mode == 4'd0) begin
          if (d == 2'd1) mc[ch] = mc[ch] + 1'b1;
          else if (d == 2'd3) mc[ch] = mc[ch] - 1'b1;
        end
        exp_pv[ch] = old;
        stable[ch] = (mc[ch] == old) ? stable[ch] + 1 : 0;
      end
    end
  endtask

  task automatic compare();
    for (int ch = 0; ch < 2; ch++) begin
      logic [W-1:0] p = (ch == 0) ? pv1 : pv2;
      logic         u = (ch == 0) ? upd1 : upd2;
      if (e_rst) begin
        check("R10 reset value", p, '0);
        check("R10 reset flag", W'(u), '0);
      end else if (e_fmt != 4'd0) begin
        check({tag, " R8 binary value vs model"}, p, exp_pv[ch]);
        check("R8 update flag", W'(u), W'(1));
      end else if (u && stable[ch] >= 32) begin
        check("R9 decimal value vs model", p, to_bcd(mc[ch]));
        bcd_seen++;
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  task automatic move(input int ch, input logic [1:0] dl, input int n);
    repeat (n) begin
      ab[ch] = ab_of(pos_of(ab[ch]) + dl);
      tick();
      tick();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int pulses;
    ab[0] = 2'b00;
    ab[1] = 2'b00;
    @(negedge clk);
    idle(5);
    rst = 1'b0;

    tag = "R11";
    move(0, 2'd1, 10);
    move(1, 2'd3, 3);
    idle(6);
    check("R2 forward steps", pv1, W'(10));
    check("R7 reverse wrap", pv2, 24'hFFFFFD);

    tag = "R3";
    ab[0] = ~ab[0];
    idle(6);
    check("R3 double jump ignored", pv1, W'(10));

    tag = "R4";
    halt = 1'b1;
    move(0, 2'd1, 5);
    move(1, 2'd1, 2);
    idle(4);
    halt = 1'b0;
    idle(6);
    check("R4 stop freezes ch1", pv1, W'(10));
    check("R4 stop freezes ch2", pv2, 24'hFFFFFD);

    tag = "R5";
    clr_v[0] = 1'b1;
    idle(6);
    check("R5 clear ch1", pv1, '0);
    check("R5 ch2 untouched", pv2, 24'hFFFFFD);
    move(0, 2'd1, 4);
    idle(6);
    check("R5 held level no re-clear", pv1, W'(4));
    clr_v[0] = 1'b0;
    idle(2);

    tag = "R6";
    ab[0] = ab_of(pos_of(ab[0]) + 2'd1);
    tick();
    tick();
    clr_v[0] = 1'b1;
    tick();
    idle(6);
    check("R6 clear beats count", pv1, '0);
    clr_v[0] = 1'b0;
    idle(2);

    tag = "R1";
    op_mode = 4'd3;
    move(0, 2'd1, 3);
    idle(4);
    op_mode = 4'd0;
    idle(6);
    check("R1 nonzero mode freezes", pv1, '0);
    move(0, 2'd1, 2);
    idle(6);
    check("R11 counting resumes", pv1, W'(2));

    tag = "R8";
    fmt_sel = 4'd5;
    move(1, 2'd1, 3);
    idle(6);
    check("R7 upward wrap", pv2, '0);
    move(1, 2'd3, 1);
    idle(6);
    check("R7 down from zero", pv2, 24'hFFFFFF);

    tag = "R9";
    fmt_sel = 4'd0;
    idle(80);
    check("R9 ch1 decimal", pv1, 24'h000002);
    check("R9 ch2 low six digits", pv2, 24'h777215);
    pulses = 0;
    for (int i = 0; i < 75; i++) begin
      tick();
      if (upd1) pulses++;
    end
    check("R9 update pulse count", W'((pulses >= 2 && pulses <= 3) ? 1 : 0), W'(1));
    move(0, 2'd1, 9);
    idle(80);
    check("R9 ch1 decimal after move", pv1, 24'h000011);
    check("R9 decimal samples taken", W'(bcd_seen > 0 ? 1 : 0), W'(1));

    tag = "R8";
    fmt_sel = 4'd1;
    idle(3);
    check("R8 back to binary", pv1, W'(11));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule